// File: doc/BRIEF.md
# Not-Taken Branch Flush Controller

This block handles control-flow recovery for a six-stage in-order pipeline (fetch, decode, operand fetch, execute, memory, write-back). Fetch always runs down the sequential path, so every branch is in effect predicted not taken. Branches resolve in the memory stage. A branch that resolves not taken costs nothing. A taken branch raises a one-cycle redirect that loads the fetch PC with the branch target. In the same cycle it pulses a kill for each younger stage register (fetch, decode, operand fetch, execute) that holds a valid instruction. With all four younger slots occupied and no delay slot, that is a four-cycle penalty.

When the delay-slot input is high, the instruction right after the branch in program order is kept and completes, which brings the penalty down to three cycles. That instruction is the oldest valid one among the younger stages, so a bubble in execute moves the exemption to operand fetch. If no younger instruction exists yet, the controller saves the target. It withholds the redirect until the delay-slot instruction shows up in fetch, then redirects without killing it.

The controller is a four-state machine:
- **RUN** is the normal state.
- **HELD** covers a branch that has already been resolved but is kept in the memory stage by a pipeline hold. Further resolutions are ignored here, and the machine returns to RUN once the hold is released.
- **SLOT_WAIT** waits for the delay-slot instruction to reach fetch with the target saved.
- **SLOT_HELD** is the same wait while the resolved branch is still held.

The transitions are:
- RUN→HELD on a taken redirect under hold.
- RUN→SLOT_WAIT or RUN→SLOT_HELD on a taken branch with an empty delay slot.
- SLOT_HELD→SLOT_WAIT on hold release.
- SLOT_WAIT→RUN and SLOT_HELD→RUN/HELD on the deferred redirect.
- HELD→RUN on hold release.

Top module: `nt_flush_ctrl`

## Requirements
- R1: After reset, with no resolution presented, `redir` is 0 and `kill` is all zero.
- R2: A resolution with `res_taken`=0 produces no redirect and no kill.
- R3: In RUN, a taken resolution whose resolving stage is valid (`stage_vld[4]`=1) with `ds_en`=0 raises `redir` in the same cycle with `redir_pc`=`res_tgt`, and `kill` equals `stage_vld[3:0]` (bit 0 fetch, bit 1 decode, bit 2 operand fetch, bit 3 execute).
- R4: With `ds_en`=1, a taken redirect kills every valid younger stage except the oldest valid one (the highest set bit of `stage_vld[3:0]`), which is kept.
- R5: A resolution whose resolving stage is invalid (`stage_vld[4]`=0, a branch already killed) produces no redirect and no kill.
- R6: The redirect and kills are raised even while `hold`=1.
- R7: After a taken redirect under `hold`, the same branch presented again produces no redirect or kill until `hold` has been low for one cycle; after that a new taken resolution acts again.
- R8: With `ds_en`=1 and no valid younger stage, a taken resolution raises no redirect. The redirect comes in the first later cycle with `stage_vld[0]`=1, with `redir_pc` equal to the target captured at resolution (even if `res_tgt` has changed) and `kill`=0.
- R9: `kill` is never nonzero without `redir`, and never covers a stage whose valid bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ds_en | input | 1 | Enable the single architectural delay slot |
| hold | input | 1 | Pipeline stall: stage registers keep their contents this cycle |
| res_vld | input | 1 | A branch outcome is presented by the memory stage |
| res_taken | input | 1 | The presented branch is taken |
| res_tgt | input | PC_W | Target of the presented branch |
| stage_vld | input | YOUNG+1 | Valid bits: [3:0] fetch..execute, [4] resolving stage |
| kill | output | YOUNG | Per-stage invalidate for the younger stage registers |
| redir | output | 1 | Load the fetch PC from `redir_pc` this cycle |
| redir_pc | output | PC_W | Redirect target |

## Verification
A machine wrongly left in HELD or one of the slot-wait states shows up at the ports on the very next taken resolution: the redirect is missing, a deferred redirect fires unasked, or a stale saved target appears on `redir_pc`. A wrong delay-slot choice shows up in the same cycle as a kill mask that is off by one bit. The directed scenarios therefore follow every state-changing event with at least one cycle that asks the machine to act again, and they compare both the redirect and the full kill mask in that cycle.

// File: rtl/nt_flush_pkg.sv
package nt_flush_pkg;

    typedef enum logic [1:0] {
        ST_RUN       = 2'd0,
        ST_HELD      = 2'd1,
        ST_SLOT_WAIT = 2'd2,
        ST_SLOT_HELD = 2'd3
    } fl_state_e;

endpackage

// File: rtl/nt_slot_pick.sv
// Selects the oldest valid younger instruction as the delay-slot survivor.
module nt_slot_pick #(
    parameter int YOUNG = 4
) (
    input  logic [YOUNG-1:0] vld,
    input  logic             en,
    output logic [YOUNG-1:0] keep,
    output logic             any
);
    logic [YOUNG:0] older_or;

    assign older_or[YOUNG] = 1'b0;

    genvar gi;
    generate
        for (gi = YOUNG - 1; gi >= 0; gi--) begin : g_scan
            assign older_or[gi] = older_or[gi+1] | vld[gi];
            assign keep[gi]     = en & vld[gi] & ~older_or[gi+1];
        end
    endgenerate

    assign any = older_or[0];

endmodule

// File: rtl/nt_tgt_latch.sv
// Holds the target while a redirect waits for the delay-slot instruction.
module nt_tgt_latch #(
    parameter int PC_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cap,
    input  logic [PC_W-1:0] d,
    output logic [PC_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= '0;
        else if (cap) q <= d;
    end
endmodule

// File: rtl/nt_flush_fsm.sv
module nt_flush_fsm
    import nt_flush_pkg::*;
#(
    parameter int YOUNG = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic             ds_en,
    input  logic             res_vld,
    input  logic             res_taken,
    input  logic             res_live,
    input  logic [YOUNG-1:0] young_vld,
    input  logic             young_any,
    input  logic [YOUNG-1:0] keep_mask,
    output logic             redir,
    output logic [YOUNG-1:0] kill,
    output logic             use_saved,
    output logic             cap_tgt
);
    fl_state_e st, st_nxt;
    logic      taken_now;
    logic      fetch_vld;

    assign taken_now = res_vld & res_taken & res_live;
    assign fetch_vld = young_vld[0];

    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_RUN;
        else        st <= st_nxt;
    end

    always_comb begin
        st_nxt    = st;
        redir     = 1'b0;
        kill      = '0;
        use_saved = 1'b0;
        cap_tgt   = 1'b0;
        unique case (st)
            ST_RUN: begin
                if (taken_now) begin
                    if (ds_en && !young_any) begin
                        cap_tgt = 1'b1;
                        st_nxt  = hold ? ST_SLOT_HELD : ST_SLOT_WAIT;
                    end else begin
                        redir  = 1'b1;
                        kill   = young_vld & ~keep_mask;
                        st_nxt = hold ? ST_HELD : ST_RUN;
                    end
                end
            end
            ST_HELD: begin
                if (!hold) st_nxt = ST_RUN;
            end
            ST_SLOT_WAIT: begin
                if (fetch_vld) begin
                    redir     = 1'b1;
                    use_saved = 1'b1;
                    st_nxt    = ST_RUN;
                end
            end
            ST_SLOT_HELD: begin
                if (fetch_vld) begin
                    redir     = 1'b1;
                    use_saved = 1'b1;
                    st_nxt    = hold ? ST_HELD : ST_RUN;
                end else if (!hold) begin
                    st_nxt = ST_SLOT_WAIT;
                end
            end
            default: st_nxt = ST_RUN;
        endcase
    end

    p_kill_needs_redir_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (kill != '0) |-> redir);

    p_kill_only_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (kill & ~young_vld) == '0);

    p_keep_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(keep_mask));

    p_dead_branch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && !res_live) |-> !redir);

    p_wait_no_kill_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SLOT_WAIT || st == ST_SLOT_HELD) |-> (kill == '0));

    p_held_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (redir && hold) |=> !redir);

endmodule

// File: rtl/nt_flush_ctrl.sv
module nt_flush_ctrl #(
    parameter int PC_W  = 32,
    parameter int YOUNG = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ds_en,
    input  logic             hold,
    input  logic             res_vld,
    input  logic             res_taken,
    input  logic [PC_W-1:0]  res_tgt,
    input  logic [YOUNG:0]   stage_vld,
    output logic [YOUNG-1:0] kill,
    output logic             redir,
    output logic [PC_W-1:0]  redir_pc
);
    localparam int RES_IDX = YOUNG;

    logic [YOUNG-1:0] young_vld;
    logic [YOUNG-1:0] keep_mask;
    logic             young_any;
    logic             use_saved;
    logic             cap_tgt;
    logic [PC_W-1:0]  saved_tgt;

    assign young_vld = stage_vld[YOUNG-1:0];

    nt_slot_pick #(.YOUNG(YOUNG)) u_pick (
        .vld  (young_vld),
        .en   (ds_en),
        .keep (keep_mask),
        .any  (young_any)
    );

    nt_tgt_latch #(.PC_W(PC_W)) u_tgt (
        .clk   (clk),
        .rst_n (rst_n),
        .cap   (cap_tgt),
        .d     (res_tgt),
        .q     (saved_tgt)
    );

    nt_flush_fsm #(.YOUNG(YOUNG)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold      (hold),
        .ds_en     (ds_en),
        .res_vld   (res_vld),
        .res_taken (res_taken),
        .res_live  (stage_vld[RES_IDX]),
        .young_vld (young_vld),
        .young_any (young_any),
        .keep_mask (keep_mask),
        .redir     (redir),
        .kill      (kill),
        .use_saved (use_saved),
        .cap_tgt   (cap_tgt)
    );

    assign redir_pc = use_saved ? saved_tgt : res_tgt;

    p_not_taken_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld && !res_taken && !use_saved) |-> !redir);

endmodule

// File: tb/nt_flush_ctrl_tb.sv
module nt_flush_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int PC_W  = 32;
    localparam int YOUNG = 4;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             ds_en, hold, res_vld, res_taken;
    logic [PC_W-1:0]  res_tgt;
    logic [YOUNG:0]   stage_vld;
    logic [YOUNG-1:0] kill;
    logic             redir;
    logic [PC_W-1:0]  redir_pc;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nt_flush_ctrl #(.PC_W(PC_W), .YOUNG(YOUNG)) dut_i (
        .clk(clk), .rst_n(rst_n), .ds_en(ds_en), .hold(hold),
        .res_vld(res_vld), .res_taken(res_taken), .res_tgt(res_tgt),
        .stage_vld(stage_vld), .kill(kill), .redir(redir), .redir_pc(redir_pc)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive one cycle of inputs after the falling edge, then let outputs settle.
    task automatic drive(input logic v, input logic t, input logic [PC_W-1:0] tg,
                         input logic [YOUNG:0] sv, input logic h, input logic ds);
        @(negedge clk);
        res_vld = v; res_taken = t; res_tgt = tg; stage_vld = sv; hold = h; ds_en = ds;
        #1;
    endtask

    task automatic idle();
        drive(1'b0, 1'b0, '0, 5'b00000, 1'b0, 1'b0);
    endtask

    task automatic t_reset();
        idle();
        chk("R1 redir", redir, 0);
        chk("R1 kill", kill, 0);
    endtask

    task automatic t_not_taken();
        drive(1, 0, 32'h100, 5'b11111, 0, 0);
        chk("R2 redir", redir, 0);
        chk("R2 kill", kill, 0);
        idle();
    endtask

    task automatic t_taken_plain();
        drive(1, 1, 32'h2000, 5'b11111, 0, 0);
        chk("R3 redir", redir, 1);
        chk("R3 pc", redir_pc, 32'h2000);
        chk("R3 kill all", kill, 4'b1111);
        idle();
        chk("R3 one pulse", redir, 0);
        drive(1, 1, 32'h2040, 5'b10101, 0, 0);
        chk("R3 kill partial", kill, 4'b0101);
        chk("R9 subset", kill & ~stage_vld[3:0], 0);
        idle();
    endtask

    task automatic t_delay_slot();
        drive(1, 1, 32'h3000, 5'b11111, 0, 1);
        chk("R4 redir", redir, 1);
        chk("R4 keep ex", kill, 4'b0111);
        idle();
        drive(1, 1, 32'h3004, 5'b11011, 0, 1);
        chk("R4 keep ex gap", kill, 4'b0011);
        idle();
        drive(1, 1, 32'h3008, 5'b10110, 0, 1);
        chk("R4 keep of", kill, 4'b0010);
        chk("R4 pc", redir_pc, 32'h3008);
        idle();
    endtask

    task automatic t_dead_branch();
        drive(1, 1, 32'h4000, 5'b01111, 0, 0);
        chk("R5 redir", redir, 0);
        chk("R5 kill", kill, 0);
        idle();
        chk("R5 later", redir, 0);
    endtask

    task automatic t_hold();
        drive(1, 1, 32'h5000, 5'b11111, 1, 0);
        chk("R6 redir under hold", redir, 1);
        chk("R6 kill under hold", kill, 4'b1111);
        drive(1, 1, 32'h5000, 5'b10000, 1, 0);
        chk("R7 no repeat", redir, 0);
        drive(1, 1, 32'h5000, 5'b10001, 0, 0);
        chk("R7 release cycle", redir, 0);
        chk("R7 release kill", kill, 0);
        drive(1, 1, 32'h5100, 5'b10011, 0, 0);
        chk("R7 acts again", redir, 1);
        chk("R7 pc", redir_pc, 32'h5100);
        idle();
    endtask

    task automatic t_slot_wait();
        drive(1, 1, 32'h6000, 5'b10000, 0, 1);
        chk("R8 deferred", redir, 0);
        drive(0, 0, 32'h6666, 5'b00000, 0, 1);
        chk("R8 still waiting", redir, 0);
        drive(0, 0, 32'h7777, 5'b00001, 0, 1);
        chk("R8 redir", redir, 1);
        chk("R8 saved pc", redir_pc, 32'h6000);
        chk("R8 no kill", kill, 0);
        idle();
        chk("R8 done", redir, 0);
    endtask

    task automatic t_slot_wait_hold();
        drive(1, 1, 32'h8000, 5'b10000, 1, 1);
        chk("R8 held deferred", redir, 0);
        drive(1, 1, 32'h8888, 5'b10000, 1, 1);
        chk("R8 held ignore", redir, 0);
        drive(1, 1, 32'h8888, 5'b10001, 1, 1);
        chk("R8 held redir", redir, 1);
        chk("R8 held pc", redir_pc, 32'h8000);
        chk("R8 held kill", kill, 0);
        drive(1, 1, 32'h8888, 5'b10001, 1, 1);
        chk("R7 after slot", redir, 0);
        drive(1, 1, 32'h8888, 5'b10001, 0, 1);
        chk("R7 release", redir, 0);
        drive(1, 1, 32'h9000, 5'b11111, 0, 0);
        chk("R3 after slot", redir_pc, 32'h9000);
        chk("R3 after slot kill", kill, 4'b1111);
        idle();
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        rst_n = 1'b0; ds_en = 0; hold = 0; res_vld = 0; res_taken = 0;
        res_tgt = '0; stage_vld = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_not_taken();
        t_taken_plain();
        t_delay_slot();
        t_dead_branch();
        t_hold();
        t_slot_wait();
        t_slot_wait_hold();
        repeat (2) @(posedge clk);
        summary();
    end

    initial begin
        #(CLK_PERIOD * 5000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
    end

endmodule